// File: doc/BRIEF.md
# Split-Transaction Expansion Bus Bridge

This block connects a CPU port to a slow peripheral controller over a shared 16-bit expansion bus. A CPU access is accepted, the bridge asks for the shared bus, and after a grant it opens a two-clock request phase with chip select asserted. If the peripheral shows ready by the end of that phase, the data beats follow at once and the whole access runs as one combined cycle.

If the peripheral is not ready, the bridge splits the access. It drops chip select and its bus request so that a display-refresh DMA master can use the bus, and it keeps the CPU stalled. Once ready is seen again, it asks for the bus again. After the grant it reasserts chip select and runs the pending data beats. A 32-bit word moves as two 16-bit halves, low half first. A byte moves in a single beat. There is no timeout: only a ready from the peripheral ends a suspended access.

Top module: `exp_split_bridge`

## Requirements
- R1: While reset is held, busReq, chipSel, cpuStall and cpuDone are low and cpuRdata is zero.
- R2: An accepted cpuReq raises busReq in the next cycle. chipSel rises only in the cycle after busGnt is sampled high, and it stays high for two request cycles.
- R3: If perReady is high at the clock edge that ends the second request cycle, the data beats start in the next cycle with chipSel and busReq held high. A fast word access asserts cpuDone five cycles after the cycle in which cpuReq is removed. A fast byte access does so after four.
- R4: If perReady is low at that edge, chipSel and busReq are both low from the next cycle, and they stay low until perReady is sampled high.
- R5: After perReady is sampled high in the suspended state, busReq is high from the next cycle and is held until busGnt is sampled high. chipSel and the data beats follow in the cycle after that.
- R6: A word access makes two data beats, with expHalf at 0 for the low half and then 1 for the high half. A byte access (expByte=1) makes a single beat with expHalf at 0.
- R7: A word read returns {second beat, first beat} on cpuRdata. A byte read returns bits 7:0 of its beat, zero-extended. cpuRdata changes only in the cycle in which cpuDone is high after a read.
- R8: During write beats, expWdata is cpuWdata[15:0] for the low half and cpuWdata[31:16] for the high half. For a byte write it is {8'h00, cpuWdata[7:0]}.
- R9: cpuStall is high from the cycle after acceptance through the last data beat. cpuDone is a one-cycle pulse in the cycle after the last beat, and cpuStall is low in that cycle.
- R10: busReq is low in the cycle after the last data beat.
- R11: A suspended access has no time limit. With perReady held low, chipSel and busReq stay low and cpuStall stays high for any number of cycles.
- R12: A cpuReq that arrives while an access is in progress is ignored. The address, direction and size of the running access do not change.
- R13: perReady is sampled only on rising clock edges. A high pulse that lies wholly between two edges does not resume a suspended access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running expansion clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU access request, sampled while idle |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuByte | input | 1 | 1 = byte access, 0 = 32-bit word |
| cpuAddr | input | ADDR_W | Access address |
| cpuWdata | input | 2*HALF_W | Write data |
| cpuStall | output | 1 | CPU hold while an access is pending |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuRdata | output | 2*HALF_W | Assembled read data |
| busReq | output | 1 | Request for the shared expansion bus |
| busGnt | input | 1 | Grant of the shared bus |
| chipSel | output | 1 | Peripheral chip select |
| expAddr | output | ADDR_W | Address of the running access |
| expWrite | output | 1 | Direction of the running access |
| expByte | output | 1 | Size of the running access |
| expHalf | output | 1 | Half being moved (0 low, 1 high) |
| expWdata | output | HALF_W | Write data for the current beat |
| expRdata | input | HALF_W | Read data from the peripheral |
| perReady | input | 1 | Peripheral ready, sampled on rising edges |

## Verification
A wrong sequencer state shows up at the ports within one clock. Examples are chip select held while the bus is released, a request that never drops during a suspension, or a missing second beat. These show as a chipSel, busReq or expHalf mismatch against the cycle model in the very next cycle. A wrong beat index or a wrong capture in the datapath stays hidden until completion. It then appears as a wrong cpuRdata in the cpuDone cycle, or as a wrong expWdata half during write beats. Suspension is also checked with long ready-low stretches, with ready pulses between clock edges, and with delayed grants. These show whether a stray resume or a lost resume leaves the CPU stalled or wakes it too early.

// File: rtl/xbridge_pkg.sv
package xbridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_REQA,
    ST_REQB,
    ST_SUSP,
    ST_REARB,
    ST_DATA
  } xbState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchCmd;
    logic capture;
    logic beatIdx;
    logic finish;
  } xbStrobe_t;

endpackage

// File: rtl/xbridge_ctrl.sv
module xbridge_ctrl
  import xbridge_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReq,
  input  logic      busGnt,
  input  logic      perReady,
  input  logic      cmdByte,
  input  logic      cmdWrite,
  output logic      busReq,
  output logic      chipSel,
  output logic      cpuStall,
  output logic      cpuDone,
  output logic      expHalf,
  output xbStrobe_t strb
);

  xbState_e state, stateNext;
  logic     beat, beatNext;
  logic     doneQ;
  logic     lastBeat;

  assign lastBeat = cmdByte || beat;

  always_comb begin
    stateNext     = state;
    beatNext      = beat;
    strb          = '0;
    strb.beatIdx  = beat;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          strb.latchCmd = 1'b1;
          stateNext     = ST_ARB;
        end
      end
      ST_ARB:   if (busGnt) stateNext = ST_REQA;
      ST_REQA:  stateNext = ST_REQB;
      ST_REQB: begin
        beatNext  = 1'b0;
        stateNext = perReady ? ST_DATA : ST_SUSP;
      end
      ST_SUSP:  if (perReady) stateNext = ST_REARB;
      ST_REARB: begin
        beatNext = 1'b0;
        if (busGnt) stateNext = ST_DATA;
      end
      ST_DATA: begin
        strb.capture = !cmdWrite;
        if (lastBeat) begin
          strb.finish = 1'b1;
          beatNext    = 1'b0;
          stateNext   = ST_IDLE;
        end else begin
          beatNext = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      beat  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      beat  <= beatNext;
      doneQ <= strb.finish;
    end
  end

  assign busReq   = (state == ST_ARB) || (state == ST_REQA) || (state == ST_REQB) ||
                    (state == ST_REARB) || (state == ST_DATA);
  assign chipSel  = (state == ST_REQA) || (state == ST_REQB) || (state == ST_DATA);
  assign cpuStall = (state != ST_IDLE);
  assign cpuDone  = doneQ;
  assign expHalf  = beat;

  AST_CS_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chipSel) |-> $past(busGnt)); // R2
  AST_CS_OWNS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    chipSel |-> busReq); // R4
  AST_SUSP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REQB && !perReady) |=> (!chipSel && !busReq)); // R4
  AST_REARB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REARB && !busGnt) |=> (busReq && !chipSel)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone); // R9
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> (!busReq && !cpuStall)); // R10
  AST_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSP && !perReady) |=> (cpuStall && !chipSel)); // R11

endmodule

// File: rtl/xbridge_dpath.sv
module xbridge_dpath
  import xbridge_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int HALF_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  xbStrobe_t           strb,
  input  logic                cpuWrite,
  input  logic                cpuByte,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [2*HALF_W-1:0] cpuWdata,
  input  logic [HALF_W-1:0]   expRdata,
  output logic [2*HALF_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0]   expAddr,
  output logic                expWrite,
  output logic                expByte,
  output logic [HALF_W-1:0]   expWdata
);

  localparam int NHALF  = 2;
  localparam int WORD_W = NHALF * HALF_W;

  logic [ADDR_W-1:0] cmdAddr;
  logic [WORD_W-1:0] cmdWdata;
  logic              cmdWrite, cmdByte;
  logic [WORD_W-1:0] rdataQ;
  logic [WORD_W-1:0] asmWord;
  logic [WORD_W-1:0] asmByte;
  logic [HALF_W-1:0] wHalf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdAddr  <= '0;
      cmdWdata <= '0;
      cmdWrite <= 1'b0;
      cmdByte  <= 1'b0;
    end else if (strb.latchCmd) begin
      cmdAddr  <= cpuAddr;
      cmdWdata <= cpuWdata;
      cmdWrite <= cpuWrite;
      cmdByte  <= cpuByte;
    end
  end

  // one capture register per half; the beat in flight bypasses its register
  for (genvar g = 0; g < NHALF; g++) begin : gHalf
    logic [HALF_W-1:0] halfReg;
    logic              hit;
    assign hit = (int'(strb.beatIdx) == g);
    always_ff @(posedge clk) begin
      if (!rstN)                     halfReg <= '0;
      else if (strb.capture && hit)  halfReg <= expRdata;
    end
    assign asmWord[g*HALF_W +: HALF_W] = hit ? expRdata : halfReg;
  end

  assign asmByte = {{(WORD_W-BYTE_W){1'b0}}, expRdata[BYTE_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN)                          rdataQ <= '0;
    else if (strb.finish && !cmdWrite)  rdataQ <= cmdByte ? asmByte : asmWord;
  end

  assign wHalf    = strb.beatIdx ? cmdWdata[WORD_W-1:HALF_W] : cmdWdata[HALF_W-1:0];
  assign expWdata = cmdByte ? {{(HALF_W-BYTE_W){1'b0}}, cmdWdata[BYTE_W-1:0]} : wHalf;

  assign cpuRdata = rdataQ;
  assign expAddr  = cmdAddr;
  assign expWrite = cmdWrite;
  assign expByte  = cmdByte;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> $stable(cpuRdata)); // R7
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchCmd |=> ($stable(expAddr) && $stable(expWrite) && $stable(expByte))); // R12

endmodule

// File: rtl/exp_split_bridge.sv
module exp_split_bridge
  import xbridge_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int HALF_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cpuReq,
  input  logic                cpuWrite,
  input  logic                cpuByte,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [2*HALF_W-1:0] cpuWdata,
  output logic                cpuStall,
  output logic                cpuDone,
  output logic [2*HALF_W-1:0] cpuRdata,
  output logic                busReq,
  input  logic                busGnt,
  output logic                chipSel,
  output logic [ADDR_W-1:0]   expAddr,
  output logic                expWrite,
  output logic                expByte,
  output logic                expHalf,
  output logic [HALF_W-1:0]   expWdata,
  input  logic [HALF_W-1:0]   expRdata,
  input  logic                perReady
);

  xbStrobe_t strb;

  xbridge_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .busGnt   (busGnt),
    .perReady (perReady),
    .cmdByte  (expByte),
    .cmdWrite (expWrite),
    .busReq   (busReq),
    .chipSel  (chipSel),
    .cpuStall (cpuStall),
    .cpuDone  (cpuDone),
    .expHalf  (expHalf),
    .strb     (strb)
  );

  xbridge_dpath #(
    .ADDR_W (ADDR_W),
    .HALF_W (HALF_W),
    .BYTE_W (BYTE_W)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cpuWrite (cpuWrite),
    .cpuByte  (cpuByte),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .expRdata (expRdata),
    .cpuRdata (cpuRdata),
    .expAddr  (expAddr),
    .expWrite (expWrite),
    .expByte  (expByte),
    .expWdata (expWdata)
  );

endmodule

// File: tb/test_exp_split_bridge.sv
module test_exp_split_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWrite = 1'b0, cpuByte = 1'b0;
  logic [23:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic        cpuStall, cpuDone, busReq, chipSel, expWrite, expByte, expHalf;
  logic [31:0] cpuRdata;
  logic [23:0] expAddr;
  logic [15:0] expWdata, expRdata;
  logic        busGnt = 1'b0;
  logic        perReady = 1'b1;

  logic [15:0] rdLo = 16'h0000, rdHi = 16'h0000;
  int          gntLag = 0;
  int          gntCnt = 0;
  int          checks = 0, errors = 0;
  int          cycles = 0;
  bit          started = 1'b0;

  always #5 clk = ~clk;

  assign expRdata = expHalf ? rdHi : rdLo;

  exp_split_bridge i_exp_split_bridge (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuByte(cpuByte),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuStall(cpuStall), .cpuDone(cpuDone),
    .cpuRdata(cpuRdata), .busReq(busReq), .busGnt(busGnt), .chipSel(chipSel),
    .expAddr(expAddr), .expWrite(expWrite), .expByte(expByte), .expHalf(expHalf),
    .expWdata(expWdata), .expRdata(expRdata), .perReady(perReady)
  );

  // bus arbiter stand-in: grant after gntLag cycles of continuous request
  always @(negedge clk) begin
    if (busReq) gntCnt = gntCnt + 1; else gntCnt = 0;
    busGnt <= busReq && (gntCnt > gntLag);
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  // phase: idle, waitGrant, request1, request2, parked, waitRegrant, moving
  typedef enum int {P_IDLE, P_WGNT, P_RQ1, P_RQ2, P_PARK, P_WREGNT, P_MOVE} phase_e;
  phase_e      mPh = P_IDLE;
  int          mBeat = 0;
  bit          mWr = 0, mBy = 0, mDone = 0;
  logic [23:0] mAddr = '0;
  logic [31:0] mWd = '0, mRd = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = P_IDLE; mBeat = 0; mDone = 0; mRd = '0; mAddr = '0; mWr = 0; mBy = 0;
    end else begin
      mDone = 0;
      case (mPh)
        P_IDLE:   if (cpuReq) begin
                    mWr = cpuWrite; mBy = cpuByte; mAddr = cpuAddr; mWd = cpuWdata;
                    mPh = P_WGNT;
                  end
        P_WGNT:   if (busGnt) mPh = P_RQ1;
        P_RQ1:    mPh = P_RQ2;
        P_RQ2:    begin mBeat = 0; mPh = perReady ? P_MOVE : P_PARK; end
        P_PARK:   if (perReady) mPh = P_WREGNT;
        P_WREGNT: if (busGnt) begin mBeat = 0; mPh = P_MOVE; end
        P_MOVE:   begin
                    if (mBy || mBeat == 1) begin
                      mDone = 1; mPh = P_IDLE; mBeat = 0;
                      if (!mWr) mRd = mBy ? {24'h0, rdLo[7:0]} : {rdHi, rdLo};
                    end else mBeat = 1;
                  end
        default:  mPh = P_IDLE;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN && started) begin
      bit eCs, eReq, eStall;
      eCs    = (mPh == P_RQ1) || (mPh == P_RQ2) || (mPh == P_MOVE);
      eReq   = eCs || (mPh == P_WGNT) || (mPh == P_WREGNT);
      eStall = (mPh != P_IDLE);
      chk(chipSel == eCs, "R4", "chipSel", 32'(chipSel), 32'(eCs));
      chk(busReq == eReq, "R5", "busReq", 32'(busReq), 32'(eReq));
      chk(cpuStall == eStall, "R9", "cpuStall", 32'(cpuStall), 32'(eStall));
      chk(cpuDone == mDone, "R9", "cpuDone", 32'(cpuDone), 32'(mDone));
      chk(cpuRdata == mRd, "R7", "cpuRdata", cpuRdata, mRd);
      if (eCs) begin
        chk(expAddr == mAddr, "R12", "expAddr", 32'(expAddr), 32'(mAddr));
        chk(expByte == mBy, "R6", "expByte", 32'(expByte), 32'(mBy));
      end
      if (mPh == P_MOVE) begin
        chk(expHalf == mBeat[0], "R6", "expHalf", 32'(expHalf), 32'(mBeat));
        if (mWr) begin
          logic [15:0] ew;
          ew = mBy ? {8'h00, mWd[7:0]} : (mBeat == 1 ? mWd[31:16] : mWd[15:0]);
          chk(expWdata == ew, "R8", "expWdata", 32'(expWdata), 32'(ew));
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic launch(input bit wr, input bit by, input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    cpuReq = 1; cpuWrite = wr; cpuByte = by; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    cpuReq = 0;
  endtask

  task automatic waitDone(output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      n++;
      if (cpuDone) return;
    end
    chk(0, "R9", "completion never seen", 32'(n), 32'(0));
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(0, "R11", "watchdog expired", 32'(cycles), 32'(150000));
      finishRun();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busReq && !chipSel && !cpuStall && !cpuDone, "R1", "control outputs in reset",
        {28'h0, busReq, chipSel, cpuStall, cpuDone}, 32'h0);
    chk(cpuRdata == 32'h0, "R1", "cpuRdata in reset", cpuRdata, 32'h0);
    rstN = 1'b1;
    started = 1'b1;

    // R3, R6, R7: fast word read
    rdLo = 16'hBEEF; rdHi = 16'hDEAD; perReady = 1; gntLag = 0;
    launch(0, 0, 24'h000100, 32'h0);
    waitDone(n);
    chk(n == 5, "R3", "fast word latency", 32'(n), 32'd5);
    chk(cpuRdata == 32'hDEADBEEF, "R7", "word read value", cpuRdata, 32'hDEADBEEF);
    @(negedge clk);
    chk(!busReq && !cpuDone, "R10", "bus released after done", {30'h0, busReq, cpuDone}, 32'h0);

    // R3, R8: fast byte write
    launch(1, 1, 24'h000202, 32'h123456A5);
    waitDone(n);
    chk(n == 4, "R3", "fast byte latency", 32'(n), 32'd4);
    chk(cpuRdata == 32'hDEADBEEF, "R7", "rdata kept across write", cpuRdata, 32'hDEADBEEF);

    // R4, R5, R13: slow byte read with delayed grant and a glitch on ready
    rdLo = 16'h7F3C; rdHi = 16'hFFFF; perReady = 0; gntLag = 2;
    launch(0, 1, 24'h000305, 32'h0);
    repeat (6) @(negedge clk);
    chk(!chipSel && !busReq && cpuStall, "R4", "parked while not ready",
        {29'h0, chipSel, busReq, cpuStall}, 32'h1);
    #1 perReady = 1;
    #2 perReady = 0;
    repeat (2) @(negedge clk);
    chk(!chipSel && !busReq, "R13", "glitch between edges ignored",
        {30'h0, chipSel, busReq}, 32'h0);
    perReady = 1;
    @(negedge clk);
    @(negedge clk);
    chk(busReq && !chipSel, "R5", "rerequest before grant", {30'h0, busReq, chipSel}, 32'h2);
    waitDone(n);
    chk(cpuRdata == 32'h0000003C, "R7", "byte read value", cpuRdata, 32'h0000003C);

    // R8, R12: slow word write with a stray request while busy
    perReady = 0; gntLag = 1;
    launch(1, 0, 24'h000400, 32'hCAFE1234);
    repeat (4) @(negedge clk);
    cpuReq = 1; cpuWrite = 0; cpuByte = 1; cpuAddr = 24'h00FFFF;
    @(negedge clk);
    cpuReq = 0;
    chk(expAddr == 24'h000400 && expWrite && !expByte, "R12", "command kept while busy",
        {7'h0, expWrite, expAddr}, {7'h0, 1'b1, 24'h000400});
    repeat (3) @(negedge clk);
    perReady = 1;
    waitDone(n);

    // R11: very long suspension, then release
    perReady = 0; gntLag = 0; rdLo = 16'h0A0B; rdHi = 16'h0C0D;
    launch(0, 0, 24'h000500, 32'h0);
    repeat (300) @(negedge clk);
    chk(!chipSel && !busReq && cpuStall, "R11", "still parked after 300 cycles",
        {29'h0, chipSel, busReq, cpuStall}, 32'h1);
    perReady = 1;
    waitDone(n);
    chk(cpuRdata == 32'h0C0D0A0B, "R7", "word read after long park", cpuRdata, 32'h0C0D0A0B);

    // R2, R6: fast word write with grant lag
    gntLag = 3;
    launch(1, 0, 24'h000600, 32'h89ABCDEF);
    @(negedge clk);
    chk(busReq && !chipSel, "R2", "request without select before grant",
        {30'h0, busReq, chipSel}, 32'h2);
    waitDone(n);

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule